// File: doc/BRIEF.md
# Exponential Retry Backoff Controller

This block sets how long a requester waits before it retries an atomic compare-and-swap that lost to another requester. It keeps a backoff amount. The amount is 1 after reset. Every accepted failure spends a delay sized by the current amount and then doubles the amount, up to a ceiling of 4096. A success brings the amount back to 1. The delay can be spent in one of two ways. In spin mode the block counts the delay down itself, holds `busy_o` high while it does, and then pulses `done_o`. In pause mode the block hands the whole scaled delay to a downstream pause unit as one request.

In spin mode, one unit of backoff costs 2^SPIN_SHIFT cycles. The default is 128 cycles, about the cost of three slow status-register reads. In pause mode the issued value is the amount shifted left by PAUSE_SHIFT (times 128). The requester drives `fail_i` after a failed attempt. It drives `start_i` to wait again at the same level, and `success_i` once the swap completes.

Top module: `exp_backoff_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o` and `pause_valid_o` are 0, and the backoff amount is 1, so the first pause request carries 128.
- R2: In spin mode, a `fail_i` sampled at a clock edge while idle raises `busy_o` after that edge. `busy_o` stays high for exactly amount×2^SPIN_SHIFT cycles. `done_o` is high for the single cycle right after `busy_o` falls.
- R3: Each accepted `fail_i` doubles the amount that the next delay uses (1, 2, 4, 8, ...).
- R4: The amount saturates at 4096. Further failures leave it at 4096 and never wrap.
- R5: `success_i` sets the amount back to 1. When `success_i` and `fail_i` (or `start_i`) are sampled together, success wins: no delay is launched and the amount is not doubled.
- R6: In pause mode (`mode_i`=1), an accepted request makes `pause_valid_o` high for the single cycle after the sampling edge, with `pause_value_o` equal to amount×128. `busy_o` and `done_o` stay 0.
- R7: In pause mode, each accepted request issues exactly one pause strobe carrying the whole scaled delay, including 524288 at the ceiling.
- R8: `fail_i` and `start_i` are ignored while `busy_o` is high. They neither lengthen the running delay nor change the amount.
- R9: `start_i` while idle launches a delay of the current amount without doubling it. `fail_i` wins over `start_i` when both are sampled together.
- R10: The mode is sampled at launch. Changing `mode_i` during a spin delay does not change that delay and raises no pause strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Wait again at the current amount |
| fail_i | input | 1 | Attempt failed: wait, then double the amount |
| success_i | input | 1 | Attempt succeeded: amount returns to 1 |
| mode_i | input | 1 | 0 = spin countdown, 1 = single pause request |
| busy_o | output | 1 | Spin delay in progress |
| done_o | output | 1 | One-cycle pulse when a spin delay ends |
| pause_valid_o | output | 1 | One-cycle strobe for a pause request |
| pause_value_o | output | LIMIT_LOG2+1+PAUSE_SHIFT (20) | Pause amount in cycles, amount×128 |

## Verification
A request sampled at a clock edge shows its effect just after that same edge. In spin mode `busy_o` is already high, and in pause mode `pause_valid_o` and `pause_value_o` are already set. `done_o` follows exactly amount×2^SPIN_SHIFT busy cycles later. The bench drives every input on the falling edge and samples on the following falling edge. This places each check half a cycle after the register that produced the value. It counts busy falling edges one by one to recover the amount. It checks `done_o` on the first falling edge with `busy_o` low, and again on the edge after that. It reads the amount at any time through one pause-mode request. The bench shortens SPIN_SHIFT to 2 so that long spin sequences stay short; pause-mode scaling keeps its default of 7.

// File: rtl/ebk_pkg.sv
package ebk_pkg;
  typedef enum logic {
    WAIT_SPIN  = 1'b0,
    WAIT_PAUSE = 1'b1
  } wait_mode_e;
endpackage

// File: rtl/ebk_level.sv
// Backoff amount register: power of two, doubled per failure, saturating.
module ebk_level #(
  parameter int LIMIT_LOG2 = 12,
  localparam int LW = LIMIT_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          advance_i,
  output logic [LW-1:0] amount_o
);
  localparam logic [LW-1:0] ONE   = LW'(1);
  localparam logic [LW-1:0] LIMIT = ONE << LIMIT_LOG2;

  logic [LW-1:0] amount_q, amount_d;
  logic          amount_en;

  always_comb begin
    amount_en = clear_i | advance_i;
    amount_d  = amount_q;
    if (clear_i) begin
      amount_d = ONE;
    end else if (advance_i && (amount_q != LIMIT)) begin
      amount_d = amount_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amount_q <= ONE;
    end else if (amount_en) begin
      amount_q <= amount_d;
    end
  end

  assign amount_o = amount_q;
endmodule

// File: rtl/ebk_spin.sv
// Internal countdown: busy for load_val cycles, then a one-cycle done.
module ebk_spin #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load_i) begin
      cnt_d  = load_val_i;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == ONE) begin
        cnt_d  = '0;
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    cnt_en = load_i | busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/ebk_pause.sv
// Single-request pause issue: one strobe carrying the whole scaled delay.
module ebk_pause #(
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  output logic          valid_o,
  output logic [PW-1:0] value_o
);
  logic [PW-1:0] value_q, value_d;
  logic          valid_q, valid_d;

  always_comb begin
    valid_d = load_i;
    value_d = load_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (load_i) begin
      value_q <= value_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign value_o = value_q;
endmodule

// File: rtl/exp_backoff_ctrl.sv
module exp_backoff_ctrl
  import ebk_pkg::*;
#(
  parameter int LIMIT_LOG2  = 12,
  parameter int SPIN_SHIFT  = 7,
  parameter int PAUSE_SHIFT = 7,
  localparam int LW = LIMIT_LOG2 + 1,
  localparam int CW = LW + SPIN_SHIFT,
  localparam int PW = LW + PAUSE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          fail_i,
  input  logic          success_i,
  input  logic          mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pause_valid_o,
  output logic [PW-1:0] pause_value_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wait_mode_e    sel_mode;
  logic          spin_busy;
  logic          launch, advance, spin_load, pause_load;
  logic [LW-1:0] amount;
  logic [CW-1:0] spin_val;
  logic [PW-1:0] pause_val;

  always_comb begin
    sel_mode   = wait_mode_e'(mode_i);
    launch     = !success_i && (fail_i || start_i) && !spin_busy;
    advance    = launch && fail_i;
    spin_load  = launch && (sel_mode == WAIT_SPIN);
    pause_load = launch && (sel_mode == WAIT_PAUSE);
    spin_val   = CW'(amount) << SPIN_SHIFT;
    pause_val  = PW'(amount) << PAUSE_SHIFT;
  end

  ebk_level #(.LIMIT_LOG2(LIMIT_LOG2)) u_level (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clear_i  (success_i),
    .advance_i(advance),
    .amount_o (amount)
  );

  ebk_spin #(.CW(CW)) u_spin (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (spin_load),
    .load_val_i(spin_val),
    .busy_o    (spin_busy),
    .done_o    (done_o)
  );

  ebk_pause #(.PW(PW)) u_pause (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (pause_load),
    .load_val_i(pause_val),
    .valid_o   (pause_valid_o),
    .value_o   (pause_value_o)
  );

  assign busy_o = spin_busy;
endmodule

// File: rtl/ebk_checker.sv
module ebk_checker #(
  parameter int LIMIT_LOG2  = 12,
  parameter int PAUSE_SHIFT = 7,
  localparam int PW = LIMIT_LOG2 + 1 + PAUSE_SHIFT
) (
  input logic          clk,
  input logic          rst_n,
  input logic          success_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pause_valid_o,
  input logic [PW-1:0] pause_value_o
);
  localparam logic [PW-1:0] MAXV = PW'(1) << (LIMIT_LOG2 + PAUSE_SHIFT);
  localparam logic [PW-1:0] MINV = PW'(1) << PAUSE_SHIFT;

  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_pause_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid_o |-> (pause_value_o <= MAXV && pause_value_o >= MINV));

  assert_success_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    success_i |=> (!pause_valid_o && !$rose(busy_o)));

  assert_pause_no_spin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid_o |-> (!busy_o && !done_o));

  assert_pause_pow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid_o |-> ($countones(pause_value_o) == 1));
endmodule

bind exp_backoff_ctrl ebk_checker #(
  .LIMIT_LOG2 (LIMIT_LOG2),
  .PAUSE_SHIFT(PAUSE_SHIFT)
) u_ebk_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .success_i    (success_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pause_valid_o(pause_valid_o),
  .pause_value_o(pause_value_o)
);

// File: tb/tb_exp_backoff_ctrl.sv
`timescale 1ns/1ps
module tb_exp_backoff_ctrl;
  localparam int LIMIT_LOG2  = 12;
  localparam int SPIN_SHIFT  = 2;
  localparam int PAUSE_SHIFT = 7;
  localparam int PW = LIMIT_LOG2 + 1 + PAUSE_SHIFT;
  localparam int UNIT = 1 << SPIN_SHIFT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, fail_i = 1'b0, success_i = 1'b0, mode_i = 1'b0;
  logic busy_o, done_o, pause_valid_o;
  logic [PW-1:0] pause_value_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  exp_backoff_ctrl #(
    .LIMIT_LOG2(LIMIT_LOG2), .SPIN_SHIFT(SPIN_SHIFT), .PAUSE_SHIFT(PAUSE_SHIFT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fail_i(fail_i),
    .success_i(success_i), .mode_i(mode_i), .busy_o(busy_o), .done_o(done_o),
    .pause_valid_o(pause_valid_o), .pause_value_o(pause_value_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One-cycle request, returns on the falling edge after the sampling edge.
  task automatic pulse(input bit f, input bit s, input bit sc);
    @(negedge clk);
    fail_i = f; start_i = s; success_i = sc;
    @(negedge clk);
    fail_i = 1'b0; start_i = 1'b0; success_i = 1'b0;
  endtask

  // Counts busy cycles of a running spin delay, optionally poking fail/start.
  task automatic measure(input int poke_at, output int n, output bit pv_seen);
    n = 0; pv_seen = 1'b0;
    while (busy_o && n < 100000) begin
      pv_seen |= pause_valid_o;
      fail_i  = (n == poke_at);
      start_i = (n == poke_at);
      n++;
      @(negedge clk);
    end
    fail_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic spin_once(input string req, input int exp_amount, input int poke_at);
    int n; bit pv;
    check(busy_o === 1'b1, {req, " busy after launch"}, busy_o, 1);
    measure(poke_at, n, pv);
    check(n == exp_amount * UNIT, {req, " busy length"}, n, exp_amount * UNIT);
    check(done_o === 1'b1, {req, " done pulse"}, done_o, 1);
    @(negedge clk);
    check(done_o === 1'b0, {req, " done one cycle"}, done_o, 0);
  endtask

  task automatic pause_read(input string req, input int exp_value);
    mode_i = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    check(pause_valid_o === 1'b1, {req, " pause strobe"}, pause_valid_o, 1);
    check(int'(pause_value_o) == exp_value, {req, " pause value"}, int'(pause_value_o), exp_value);
    check(busy_o === 1'b0 && done_o === 1'b0, {req, " no spin in pause mode"}, busy_o, 0);
    @(negedge clk);
    check(pause_valid_o === 1'b0, {req, " single strobe"}, pause_valid_o, 1'b0);
    mode_i = 1'b0;
  endtask

  task automatic test_reset_R1();
    check(busy_o === 1'b0, "R1 busy", busy_o, 0);
    check(done_o === 1'b0, "R1 done", done_o, 0);
    check(pause_valid_o === 1'b0, "R1 pause_valid", pause_valid_o, 0);
    pause_read("R1", 128);
  endtask

  task automatic test_spin_R2();
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    spin_once("R2", 1, -1);
  endtask

  task automatic test_double_R3();
    pulse(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      pulse(1'b1, 1'b0, 1'b0);
      spin_once("R3", 1 << i, -1);
    end
  endtask

  task automatic test_saturate_R4();
    pulse(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 15; i++) begin
      int a = (i > LIMIT_LOG2) ? (1 << LIMIT_LOG2) : (1 << i);
      pause_read((i >= LIMIT_LOG2) ? "R4 R7 ceiling" : "R7", a << PAUSE_SHIFT);
    end
  endtask

  task automatic test_success_R5();
    pulse(1'b0, 1'b0, 1'b1);
    pause_read("R5 warm", 128);
    pause_read("R5 warm", 256);
    mode_i = 1'b1;
    pulse(1'b1, 1'b0, 1'b1);
    check(pause_valid_o === 1'b0, "R5 success beats fail", pause_valid_o, 0);
    pulse(1'b0, 1'b1, 1'b1);
    check(pause_valid_o === 1'b0, "R5 success beats start", pause_valid_o, 0);
    mode_i = 1'b0;
    pause_read("R5 back to 1", 128);
  endtask

  task automatic test_pause_R6();
    pulse(1'b0, 1'b0, 1'b1);
    pause_read("R6", 128);
    pause_read("R6", 256);
  endtask

  task automatic test_ignore_R8();
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    spin_once("R8 warm", 1, -1);
    pulse(1'b1, 1'b0, 1'b0);
    spin_once("R8 poke during busy", 2, 2);
    pause_read("R8 amount unchanged", 4 << PAUSE_SHIFT);
  endtask

  task automatic test_start_R9();
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    spin_once("R9 start", 1, -1);
    pulse(1'b0, 1'b1, 1'b0);
    spin_once("R9 start again", 1, -1);
    pulse(1'b1, 1'b1, 1'b0);
    spin_once("R9 fail with start", 1, -1);
    pulse(1'b1, 1'b0, 1'b0);
    spin_once("R9 after fail", 2, -1);
  endtask

  task automatic test_mode_R10();
    int n; bit pv;
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    mode_i = 1'b1;
    measure(-1, n, pv);
    check(n == UNIT, "R10 busy length", n, UNIT);
    check(pv == 1'b0, "R10 no pause strobe", pv, 0);
    check(done_o === 1'b1, "R10 done", done_o, 1);
    mode_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset_R1();
    test_spin_R2();
    test_double_R3();
    test_saturate_R4();
    test_success_R5();
    test_pause_R6();
    test_ignore_R8();
    test_start_R9();
    test_mode_R10();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule